// File: doc/BRIEF.md
# Fractional-Rate Serial Byte Receiver

This block receives asynchronous serial characters on a single input line and returns each byte on a parallel port. A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. All bit timing comes from the block's own clock. An integer divider sets the base bit length. An 8-bit modulation pattern adds zero or one extra clock to each bit, so the average bit period can be a fraction of the clock rate.

The line first passes through a two-stage synchronizer. A high-to-low change on the synchronized line starts a frame. The start bit is tested about half a bit later, which lets the receiver reject short pulses that are not real start bits. Each bit value is set by a majority vote over three consecutive synchronized samples. When the stop bit is evaluated, the block raises a one-cycle strobe with the byte and a framing-error flag.

Top module: `uart_mod_rx`

## Requirements
- R1: `rxd` passes through two synchronizing flip-flops. A frame starts only when the synchronized line goes from high to low while the receiver is idle. The clock edge that accepts this change is the third rising edge that sees `rxd` low.
- R2: Let D be the effective divider and m_k be bit k of `mod`. The start bit is decided int(D/2)+m0 cycles after the accepting edge. Bit j (start = 0, data bit i = i+1, stop = 9) is decided D + m_(j mod 8) cycles after bit j−1. So `data_valid` is first seen high (3 + int(D/2) + m0 + Σ_{j=1..9}(D + m_(j mod 8))) rising edges after `rxd` is first driven low.
- R3: Each bit value is the majority of three consecutive synchronized samples that end at its decision edge. A pulse of one clock cycle inside a bit does not change the received value.
- R4: If the start bit votes high, the receiver goes back to idle and gives no strobe, no new data and no flag change.
- R5: The data bits are placed LSB first into `data`, so the first data bit received ends up in `data[0]`.
- R6: `data_valid` is high for exactly one cycle, right after the stop-bit decision. `data` and `frame_err` change only in that cycle.
- R7: A low stop vote sets `frame_err` = 1 together with the strobe. A high stop vote sets it to 0. The value is held until the next strobe.
- R8: After a framing error, `busy` stays high and no new frame is accepted until the synchronized line has been high.
- R9: A `div` value below 3 behaves exactly as 3.
- R10: After reset, `data`, `data_valid`, `frame_err` and `busy` are all 0. `busy` is high from the accepting edge until the receiver is idle again. After a good stop bit, `busy` is already low in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used for all bit timing |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Raw serial line, high when idle |
| div | input | DIV_W | Base bit length in clocks (minimum 3) |
| mod | input | 8 | Extra-cycle pattern, bit k used by bit index k mod 8 |
| data | output | 8 | Last received byte |
| data_valid | output | 1 | One-cycle strobe for a new byte |
| frame_err | output | 1 | Stop bit of the last byte was low |
| busy | output | 1 | A frame is being received or the line is awaited high |

## Verification
The bench records the exact edge at which each strobe must appear. If the half-bit offset, the per-bit modulation index or the wrap back to m0 and m1 were off by even one cycle, the arrival check would fail. Single-cycle pulses are placed inside the data bits. A design that took a single sample instead of a vote would return a corrupted byte. A short low pulse must give no strobe at all, so a design without false-start rejection would produce an unexpected byte. The bench also holds the line low after a low stop bit to show that no frame restarts, and it drives divider values 0 and 1, which must give bit timing identical to a divider of 3.

// File: rtl/uart_mod_rx.sv
module uart_mod_rx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic [DIV_W-1:0] div,
  input  logic [7:0]       mod,
  output logic [7:0]       data,
  output logic             data_valid,
  output logic             frame_err,
  output logic             busy
);
  localparam int CW = DIV_W + 1;
  localparam logic [3:0] LAST = 4'd9;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} state_t;

  state_t        st;
  logic [1:0]    sy;
  logic [1:0]    sh;
  logic          rx_s;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [7:0]    sreg;
  logic [CW-1:0] dv;
  logic [CW-1:0] half;
  logic [3:0]    nxt;
  logic          vote;

  assign rx_s = sy[1];
  assign dv   = (div < DIV_W'(3)) ? CW'(3) : CW'(div);
  assign half = (dv >> 1) + CW'(mod[0]);
  assign nxt  = idx + 4'd1;
  assign vote = (sh[1] & sh[0]) | (sh[1] & rx_s) | (sh[0] & rx_s);
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy <= 2'b11;
      sh <= 2'b11;
    end else begin
      sy <= {sy[0], rxd};
      sh <= {sh[0], rx_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      idx        <= '0;
      sreg       <= '0;
      data       <= '0;
      data_valid <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      case (st)
        S_IDLE: if (!rx_s && sh[0]) begin
          st  <= S_RUN;
          cnt <= half - CW'(1);
          idx <= '0;
        end
        S_RUN: begin
          if (cnt != '0) begin
            cnt <= cnt - CW'(1);
          end else if (idx == 4'd0 && vote) begin
            st <= S_IDLE;
          end else if (idx == LAST) begin
            data       <= sreg;
            data_valid <= 1'b1;
            frame_err  <= !vote;
            st         <= vote ? S_IDLE : S_HOLD;
          end else begin
            if (idx != 4'd0) sreg <= {vote, sreg[7:1]};
            idx <= nxt;
            cnt <= dv + CW'(mod[nxt[2:0]]) - CW'(1);
          end
        end
        S_HOLD: if (rx_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_mod_rx_chk.sv
module uart_mod_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_s,
  input logic [7:0] data,
  input logic       data_valid,
  input logic       frame_err,
  input logic       busy
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) data_valid |=> !data_valid); // R6
  AST_DATA_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(data) |-> data_valid); // R6
  AST_FERR_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(frame_err) |-> data_valid); // R7
  AST_START_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(!rx_s)); // R1
  AST_GOOD_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (data_valid && !frame_err) |-> !busy); // R10
  AST_BAD_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (data_valid && frame_err) |-> busy); // R8
endmodule

bind uart_mod_rx uart_mod_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .data(data),
  .data_valid(data_valid), .frame_err(frame_err), .busy(busy)
);

// File: tb/uart_mod_rx_tb.sv
module uart_mod_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic [15:0] div = 16'd13;
  logic [7:0]  mod = 8'b0000_0011;
  logic [7:0]  data;
  logic        data_valid, frame_err, busy;

  typedef struct {
    logic [7:0] d;
    logic       fe;
    int         t;
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, tests = 0, fails = 0, n_valid = 0;
  logic prev_valid = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_mod_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .div(div), .mod(mod),
    .data(data), .data_valid(data_valid), .frame_err(frame_err), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_div();
    return (div < 3) ? 3 : int'(div);
  endfunction

  // Monitor: pop expected items on each strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_valid) chk(!data_valid, "R6 strobe width", data_valid, 0);
      if (data_valid) begin
        n_valid++;
        if (q.size() == 0) begin
          chk(1'b0, "R4 unexpected strobe", data, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(data == e.d, {e.tag, " R5 data"}, data, e.d);
          chk(frame_err == e.fe, {e.tag, " R7 frame_err"}, frame_err, e.fe);
          chk(cyc == e.t, {e.tag, " R2 arrival edge"}, cyc, e.t);
        end
      end
      prev_valid = data_valid;
    end
  end

  task automatic hold(input logic lvl, input int n);
    for (int c = 0; c < n; c++) begin
      rxd = lvl;
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] d, input bit stop_hi, input int gbit,
                      input int extra_low, input string tag);
    int dv, half, tot, dur;
    exp_t e;
    logic lvl;
    dv = eff_div();
    half = dv / 2 + int'(mod[0]);
    tot = 0;
    for (int j = 1; j <= 9; j++) tot += dv + int'(mod[j % 8]);
    e.d = d; e.fe = !stop_hi; e.t = cyc + 3 + half + tot; e.tag = tag;
    q.push_back(e);
    for (int j = 0; j <= 9; j++) begin
      dur = dv + int'(mod[j % 8]);
      lvl = (j == 0) ? 1'b0 : (j == 9) ? logic'(stop_hi) : d[j-1];
      for (int c = 0; c < dur; c++) begin
        rxd = (j == gbit && c == dur / 2) ? ~lvl : lvl;
        @(negedge clk);
      end
    end
    if (!stop_hi && extra_low > 0) begin
      hold(1'b0, extra_low / 2);
      chk(busy == 1'b1, "R8 busy while line low", busy, 1);
      hold(1'b0, extra_low - extra_low / 2);
    end
    hold(1'b1, 2 * dv + 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int nv;
    repeat (4) @(negedge clk);
    chk(data_valid == 1'b0, "R10 reset valid", data_valid, 0);
    chk(frame_err == 1'b0, "R10 reset frame_err", frame_err, 0);
    chk(busy == 1'b0, "R10 reset busy", busy, 0);
    chk(data == 8'h00, "R10 reset data", data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    send(8'hA5, 1'b1, -1, 0, "R2 div13 A5");
    send(8'h3C, 1'b1, -1, 0, "R5 div13 3C");

    // False start: two low cycles only
    nv = n_valid;
    hold(1'b0, 2);
    rxd = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy after accepted edge", busy, 1);
    hold(1'b1, 40);
    chk(busy == 1'b0, "R4 idle after false start", busy, 0);
    chk(n_valid == nv, "R4 no strobe on false start", n_valid, nv);
    chk(data == 8'h3C, "R4 data untouched", data, 8'h3C);

    send(8'h5A, 1'b1, 4, 0, "R3 glitch in D3");
    send(8'hC3, 1'b1, 0, 0, "R3 glitch in start");
    send(8'h96, 1'b0, -1, 0, "R7 low stop");
    send(8'h0F, 1'b0, -1, 40, "R8 held low");
    send(8'hF0, 1'b1, -1, 0, "R7 clear after good");

    div = 16'd16; mod = 8'hB6;
    send(8'h81, 1'b1, -1, 0, "R2 div16 B6");
    send(8'h7E, 1'b1, 8, 0, "R3 glitch in D7");

    div = 16'd1; mod = 8'hFF;
    send(8'h6D, 1'b1, -1, 0, "R9 div1");
    div = 16'd0;
    send(8'h92, 1'b1, -1, 0, "R9 div0");
    div = 16'd3;
    send(8'h2B, 1'b1, -1, 0, "R9 div3");

    repeat (40) @(negedge clk);
    chk(q.size() == 0, "R6 all bytes strobed", q.size(), 0);
    chk(busy == 1'b0, "R10 idle at end", busy, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule